// File: doc/BRIEF.md
# Watch Interval Timer

This block is an interval timer of the kind used to keep real time. A source tick drives a chain of counters: a 14-bit binary low counter followed by a 7-bit high counter. The source is either a slow sub-clock tick, or the main clock divided by 64, 128 or 256. Each clock is modelled as a single-cycle enable pulse in the one system clock domain. An interval field chooses when the interrupt flag is raised. It can be raised at one of three fixed power-of-two taps of the low counter. It can also be raised in a compare mode, where the high counter is matched against a programmable 7-bit value and reloaded on a match.

Software-style control arrives as plain register inputs: an enable, the source select, the interval select, the 7-bit compare value and a one-cycle clear command. The current high counter value is always readable. The interrupt flag stays raised until an acknowledge pulse clears it. If a new event arrives in the same cycle as the acknowledge, the flag stays raised.

Top module: `wtimer`

## Requirements
- R1: After reset, irq_flag is 0 and cnt_rd is 0.
- R2: While enabled, the low counter advances by one on each source tick and wraps after 2^14 ticks. The high counter advances by one on each low-counter wrap (modulo 128 outside compare mode), and cnt_rd always shows the high counter.
- R3: Interval select 2'b00 raises the flag on each source tick that completes a block of 2^7 ticks, meaning the low counter's bits [6:0] were all ones. 2'b01 does the same for 2^13 ticks (bits [12:0]) and 2'b10 for 2^14 ticks (the full low counter). The flag is visible in the cycle after that tick.
- R4: Source select 2'b00 takes sub_tick as the source tick. 2'b01, 2'b10 and 2'b11 take one tick per 256, 128 and 64 fx_tick pulses, counted by an 8-bit prescaler that starts from zero.
- R5: Interval select 2'b11 is compare mode. When the low counter wraps while the high counter equals cmp_val, the flag is raised and the high counter reloads to 0. This gives one event every 2^14 × (cmp_val+1) ticks.
- R6: A cycle with clr_cmd at 1 zeroes the prescaler, the low counter and the high counter, has priority over a tick in that cycle, and produces no event.
- R7: While run_en is 0, all counters are held at zero and no tick or event occurs. The interrupt flag keeps its value.
- R8: The flag stays set until irq_ack is 1. An event in the same cycle as irq_ack leaves the flag set.
- R9: Changes to src_sel or ivl_sel while enabled apply from the next source tick and do not reset any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | Sub-clock enable pulse |
| fx_tick | input | 1 | Main-clock enable pulse |
| run_en | input | 1 | Count enable; 0 holds counters at zero |
| src_sel | input | 2 | Source tick select |
| ivl_sel | input | 2 | Interrupt interval select |
| cmp_val | input | 7 | Compare value for compare mode |
| clr_cmd | input | 1 | One-cycle counter clear |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_flag | output | 1 | Interrupt flag |
| cnt_rd | output | 7 | High counter readback |

## Verification
Every cycle, the assertions check the flag rules: it holds without an acknowledge, a same-cycle event beats the acknowledge, and it rises only after an event. They also check that clear, disable and a compare reload leave the readback at zero, and that the high counter moves only on a low-counter wrap. The exact tick spacing of each source divider is shown only by the bench, and so are the tap periods and the compare interval length. The bench shows these by comparing the flag and readback every cycle against an arithmetic model, including mid-run select changes.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [1:0] {
    SRC_SUB   = 2'b00,
    SRC_FX256 = 2'b01,
    SRC_FX128 = 2'b10,
    SRC_FX64  = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    IVL_TAP_A = 2'b00,
    IVL_TAP_B = 2'b01,
    IVL_FULL  = 2'b10,
    IVL_CMP   = 2'b11
  } ivl_sel_e;

  // True when the lowest n bits of v are all ones.
  function automatic logic low_bits_full(input logic [31:0] v, input int n);
    logic [31:0] mask;
    mask = (32'd1 << n) - 32'd1;
    return (v & mask) == mask;
  endfunction

  // Next value of the high counter at a low-counter wrap.
  function automatic logic [31:0] hi_next(input logic [31:0] hi,
                                          input logic reload);
    return reload ? 32'd0 : hi + 32'd1;
  endfunction

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int DIV_LOG0  = 6,
  parameter int DIV_STEPS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       fx_tick,
  input  logic       sub_tick,
  input  logic [1:0] src_sel,
  output logic       src_tick
);
  import wt_pkg::*;

  localparam int PS_W = DIV_LOG0 + DIV_STEPS - 1;

  logic [PS_W-1:0]      ps_cnt;
  logic [DIV_STEPS-1:0] div_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)       ps_cnt <= '0;
    else if (!active) ps_cnt <= '0;
    else if (fx_tick) ps_cnt <= ps_cnt + 1'b1;
  end

  for (genvar i = 0; i < DIV_STEPS; i++) begin : g_div
    assign div_tick[i] = fx_tick && low_bits_full(32'(ps_cnt), DIV_LOG0 + i);
  end

  logic raw_tick;
  always_comb begin
    unique case (src_sel_e'(src_sel))
      SRC_SUB:   raw_tick = sub_tick;
      SRC_FX256: raw_tick = div_tick[DIV_STEPS-1];
      SRC_FX128: raw_tick = div_tick[1];
      SRC_FX64:  raw_tick = div_tick[0];
      default:   raw_tick = 1'b0;
    endcase
  end

  assign src_tick = active && raw_tick;
endmodule

// File: rtl/wt_chain.sv
module wt_chain #(
  parameter int LO_W = 14,
  parameter int HI_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            src_tick,
  input  logic            cmp_mode,
  input  logic [HI_W-1:0] cmp_val,
  output logic [LO_W-1:0] lo_cnt,
  output logic [HI_W-1:0] hi_cnt,
  output logic            lo_wrap,
  output logic            cmp_hit
);
  import wt_pkg::*;

  assign lo_wrap = src_tick && low_bits_full(32'(lo_cnt), LO_W);
  assign cmp_hit = lo_wrap && (hi_cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (!active) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (src_tick) begin
      lo_cnt <= lo_cnt + 1'b1;
      if (lo_wrap) hi_cnt <= HI_W'(hi_next(32'(hi_cnt), cmp_mode && cmp_hit));
    end
  end
endmodule

// File: rtl/wt_event_sel.sv
module wt_event_sel #(
  parameter int LO_W  = 14,
  parameter int TAP_A = 7,
  parameter int TAP_B = 13
) (
  input  logic            src_tick,
  input  logic [LO_W-1:0] lo_cnt,
  input  logic [1:0]      ivl_sel,
  input  logic            cmp_hit,
  output logic            evt
);
  import wt_pkg::*;

  always_comb begin
    unique case (ivl_sel_e'(ivl_sel))
      IVL_TAP_A: evt = src_tick && low_bits_full(32'(lo_cnt), TAP_A);
      IVL_TAP_B: evt = src_tick && low_bits_full(32'(lo_cnt), TAP_B);
      IVL_FULL:  evt = src_tick && low_bits_full(32'(lo_cnt), LO_W);
      IVL_CMP:   evt = cmp_hit;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/wt_irq.sv
module wt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (ack) flag <= 1'b0;
  end
endmodule

// File: rtl/wtimer.sv
module wtimer #(
  parameter int LO_W     = 14,
  parameter int HI_W     = 7,
  parameter int TAP_A    = 7,
  parameter int TAP_B    = 13,
  parameter int DIV_LOG0 = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sub_tick,
  input  logic            fx_tick,
  input  logic            run_en,
  input  logic [1:0]      src_sel,
  input  logic [1:0]      ivl_sel,
  input  logic [HI_W-1:0] cmp_val,
  input  logic            clr_cmd,
  input  logic            irq_ack,
  output logic            irq_flag,
  output logic [HI_W-1:0] cnt_rd
);
  import wt_pkg::*;

  logic            active;
  logic            src_tick;
  logic            cmp_mode;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;
  logic            lo_wrap;
  logic            cmp_hit;
  logic            evt;

  assign active   = run_en && !clr_cmd;
  assign cmp_mode = (ivl_sel_e'(ivl_sel) == IVL_CMP);

  wt_prescaler #(.DIV_LOG0(DIV_LOG0), .DIV_STEPS(3)) u_pre (
    .clk(clk), .rst_n(rst_n), .active(active), .fx_tick(fx_tick),
    .sub_tick(sub_tick), .src_sel(src_sel), .src_tick(src_tick)
  );

  wt_chain #(.LO_W(LO_W), .HI_W(HI_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .active(active), .src_tick(src_tick),
    .cmp_mode(cmp_mode), .cmp_val(cmp_val), .lo_cnt(lo_cnt),
    .hi_cnt(hi_cnt), .lo_wrap(lo_wrap), .cmp_hit(cmp_hit)
  );

  wt_event_sel #(.LO_W(LO_W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_evt (
    .src_tick(src_tick), .lo_cnt(lo_cnt), .ivl_sel(ivl_sel),
    .cmp_hit(cmp_hit), .evt(evt)
  );

  wt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ack(irq_ack), .flag(irq_flag)
  );

  assign cnt_rd = hi_cnt;
endmodule

// File: rtl/wtimer_chk.sv
module wtimer_chk #(
  parameter int HI_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run_en,
  input logic            clr_cmd,
  input logic            irq_ack,
  input logic            irq_flag,
  input logic [HI_W-1:0] cnt_rd,
  input logic            src_tick,
  input logic            lo_wrap,
  input logic            cmp_hit,
  input logic            cmp_mode,
  input logic            evt
);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !irq_ack |=> irq_flag);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> irq_flag);
  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !evt |=> !irq_flag);
  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(evt));
  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> cnt_rd == '0);
  // R7
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !src_tick && !evt);
  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> cnt_rd == '0);
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_mode && cmp_hit && run_en && !clr_cmd |=> cnt_rd == '0);
  // R2
  hi_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !clr_cmd && !lo_wrap |=> $stable(cnt_rd));
endmodule

bind wtimer wtimer_chk #(.HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .clr_cmd(clr_cmd),
  .irq_ack(irq_ack), .irq_flag(irq_flag), .cnt_rd(cnt_rd),
  .src_tick(src_tick), .lo_wrap(lo_wrap), .cmp_hit(cmp_hit),
  .cmp_mode(cmp_mode), .evt(evt)
);

// File: tb/wtimer_test.sv
module wtimer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_tick = 1'b0, fx_tick = 1'b0, run_en = 1'b0;
  logic [1:0] src_sel = 2'b00, ivl_sel = 2'b00;
  logic [6:0] cmp_val = 7'd0;
  logic clr_cmd = 1'b0, irq_ack = 1'b0;
  logic irq_flag;
  logic [6:0] cnt_rd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wtimer uut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .fx_tick(fx_tick),
    .run_en(run_en), .src_sel(src_sel), .ivl_sel(ivl_sel),
    .cmp_val(cmp_val), .clr_cmd(clr_cmd), .irq_ack(irq_ack),
    .irq_flag(irq_flag), .cnt_rd(cnt_rd)
  );

  // Reference model, restated as counts of ticks.
  int  m_fx, m_lo, m_hi;
  bit  m_flag;

  function automatic bit src_fires(int sel, bit sub, bit fx, int fxcount);
    case (sel)
      0: return sub;
      1: return fx && ((fxcount % 256) == 255);
      2: return fx && ((fxcount % 128) == 127);
      default: return fx && ((fxcount % 64) == 63);
    endcase
  endfunction

  function automatic bit evt_fires(int sel, int lo, int hi, int cmp);
    case (sel)
      0: return ((lo + 1) % 128) == 0;
      1: return ((lo + 1) % 8192) == 0;
      2: return ((lo + 1) % 16384) == 0;
      default: return (((lo + 1) % 16384) == 0) && (hi == cmp);
    endcase
  endfunction

  always @(posedge clk) begin
    bit tk, ev;
    cycles++;
    if (!rst_n) begin
      m_fx = 0; m_lo = 0; m_hi = 0; m_flag = 0;
    end else if (!run_en || clr_cmd) begin
      m_fx = 0; m_lo = 0; m_hi = 0;
      if (irq_ack) m_flag = 0;
    end else begin
      tk = src_fires(src_sel, sub_tick, fx_tick, m_fx);
      ev = tk && evt_fires(ivl_sel, m_lo, m_hi, cmp_val);
      if (fx_tick) m_fx = (m_fx + 1) % 256;
      if (tk) begin
        if (m_lo == 16383) begin
          if (ivl_sel == 2'b11 && m_hi == cmp_val) m_hi = 0;
          else m_hi = (m_hi + 1) % 128;
        end
        m_lo = (m_lo + 1) % 16384;
      end
      if (ev) m_flag = 1;
      else if (irq_ack) m_flag = 0;
    end
  end

  task automatic check(string tag, bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_model(string tag);
    check(tag, irq_flag === m_flag, "irq_flag", int'(irq_flag), int'(m_flag));
    check(tag, cnt_rd === m_hi[6:0], "cnt_rd", int'(cnt_rd), m_hi);
  endtask

  // One cycle: inputs are already driven; wait for the edge, then compare at the falling edge.
  task automatic step(string tag);
    @(negedge clk);
    cmp_model(tag);
  endtask

  task automatic run_phase(string tag, int n, int src, int ivl, int cmp,
                           int sub_pct, int ack_pct);
    src_sel = 2'(src); ivl_sel = 2'(ivl); cmp_val = 7'(cmp);
    for (int i = 0; i < n; i++) begin
      sub_tick = ($urandom % 100) < sub_pct;
      fx_tick  = 1'b1;
      irq_ack  = ($urandom % 100) < ack_pct;
      step(tag);
    end
    irq_ack = 1'b0;
  endtask

  task automatic pulse_clr(string tag);
    clr_cmd = 1'b1;
    step(tag);
    clr_cmd = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", irq_flag === 1'b0, "irq_flag after reset", int'(irq_flag), 0);
    check("R1", cnt_rd === 7'd0, "cnt_rd after reset", int'(cnt_rd), 0);
    run_en = 1'b1;

    // R3: 2^7 tap with an irregular sub-clock
    run_phase("R3", 3000, 0, 0, 0, 75, 5);
    // R8: acknowledge held high, colliding with events
    run_phase("R8", 600, 0, 0, 0, 100, 100);
    check("R8", irq_flag === 1'b0, "flag after held ack", int'(irq_flag), 0);
    // R4: divided main clock sources
    pulse_clr("R6");
    run_phase("R4", 17000, 3, 0, 0, 0, 3);
    // R9: source change without clearing
    run_phase("R9", 17000, 2, 0, 0, 0, 3);
    run_phase("R4", 33000, 1, 0, 0, 0, 3);
    // R3: 2^13 tap, then R9 interval change mid-run
    run_phase("R3", 9000, 0, 1, 0, 100, 2);
    run_phase("R9", 500, 0, 0, 0, 100, 2);

    // R2: full 2^14 tap from a cleared chain; high counter reaches 1
    pulse_clr("R6");
    run_phase("R2", 16400, 0, 2, 0, 100, 0);
    check("R2", cnt_rd === 7'd1, "cnt_rd after 2^14 ticks", int'(cnt_rd), 1);
    check("R3", irq_flag === 1'b1, "flag after 2^14 ticks", int'(irq_flag), 1);

    // R6: clear zeroes the readback
    pulse_clr("R6");
    check("R6", cnt_rd === 7'd0, "cnt_rd after clear", int'(cnt_rd), 0);

    // R5: compare with N=1 gives an event after 2^15 ticks
    irq_ack = 1'b1; step("R8"); irq_ack = 1'b0;
    run_phase("R5", 20000, 0, 3, 1, 100, 0);
    check("R5", cnt_rd === 7'd1, "cnt_rd mid compare", int'(cnt_rd), 1);
    check("R5", irq_flag === 1'b0, "no early compare event", int'(irq_flag), 0);
    run_phase("R5", 12800, 0, 3, 1, 100, 0);
    check("R5", irq_flag === 1'b1, "compare event seen", int'(irq_flag), 1);
    check("R5", cnt_rd === 7'd0, "cnt_rd reloaded", int'(cnt_rd), 0);

    // R7: disable holds zero and keeps the flag
    run_en = 1'b0;
    run_phase("R7", 40, 0, 0, 0, 100, 0);
    check("R7", cnt_rd === 7'd0, "cnt_rd while disabled", int'(cnt_rd), 0);
    check("R7", irq_flag === 1'b1, "flag kept while disabled", int'(irq_flag), 1);
    run_en = 1'b1;

    // Constrained random mix of selects and compare values (R9)
    for (int k = 0; k < 10; k++)
      run_phase("R9", 2000, $urandom % 4, $urandom % 4, $urandom % 2,
                50 + ($urandom % 51), $urandom % 10);

    done = 1'b1;
  end

  initial begin
    wait (done || cycles >= WATCHDOG);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule